// File: doc/BRIEF.md
# Indexed Bank Address Generator

This block forms the 24-bit effective address of an absolute-indexed data access. An 8-bit bank value sits in the top byte. A 16-bit absolute operand and a 16-bit index are added to it as one full-width sum. The carry out of the low 16 bits therefore reaches the bank byte. That carry is produced the same way whatever the processor's emulation state. The bank value arrives as a plain input, so the block never writes back to any bank register.

Two optional behaviours imitate a machine with only 16 address bits. A compatibility wrap keeps the carry inside the low 16 bits. A high-byte gate clears bits 23..16 while the processor reports emulation mode and the gate enable is set. The processor drives the emulation state, so the block takes it as an input. It keeps a registered copy of that state, which reads 1 after reset. The address and a bank-crossed flag are registered and appear one cycle after a strobe.

Top module: `idx_bank_agen`

## Requirements
- R1: One clock edge after `strobe_i` is sampled high, `addr_o` holds (bank·2^16 + operand + index), with the index chosen as R4 describes and no mode active.
- R2: A carry out of bit 15 of operand + index raises bits 23..16 to bank+1. This holds whether the emulation state is 0 or 1; for example, bank $00, operand $FFFF and index $0001 give $010000.
- R3: A sum above $FFFFFF wraps modulo 2^24. For example, bank $FF, operand $FFFF and index $0001 give $000000.
- R4: When `idx_narrow_i` is 1, only `index_i[7:0]` is used, zero-extended to 16 bits. When it is 0, all 16 bits are used.
- R5: When `wrap16_i` is 1, `addr_o` is {bank, (operand + index) mod 2^16}. For example, bank $00, operand $FFF0 and index $0010 give $000000.
- R6: When the registered emulation state is 1 and `hi_gate_en_i` is 1 at the strobe, `addr_o[23:16]` is 0. This gate is applied after the R5 wrap.
- R7: The registered emulation state is 1 after reset. After that it copies `emu_i` at each clock edge, so a strobe on the first edge after reset sees state 1.
- R8: `cross_o` is registered together with `addr_o`. It is 1 exactly when bits 23..16 of the full sum differ from the bank input, where the full sum is taken modulo 2^24 with neither the R5 wrap nor the R6 gate applied.
- R9: While `strobe_i` is 0, `addr_o` and `cross_o` keep their values, whatever the other inputs do.
- R10: A synchronous reset clears `addr_o` and `cross_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_i | input | 1 | Capture a new address at this edge |
| bank_i | input | 8 | Data bank value, top byte of the sum |
| operand_i | input | 16 | Absolute operand |
| index_i | input | 16 | Index register value |
| idx_narrow_i | input | 1 | 1 selects the 8-bit index |
| emu_i | input | 1 | Emulation state reported by the processor |
| wrap16_i | input | 1 | 1 keeps the carry inside the low 16 bits |
| hi_gate_en_i | input | 1 | Enables clearing the high byte in emulation state |
| addr_o | output | 24 | Registered effective address |
| cross_o | output | 1 | Registered bank-crossed flag |

## Verification
The bench builds the block with its default widths: an 8-bit bank and 16-bit operand and index. With these widths, every boundary named in the requirements is a concrete value. The sweeps run the index through a full byte at operands just below $FFFF. Every carry position into the bank byte is therefore exercised in each mode combination, including the top-bank wrap past $FFFFFF. A model in the bench works out the expected address and flag with integer arithmetic.

// File: rtl/idx_agen_pkg.sv
package idx_agen_pkg;
  typedef struct packed {
    logic narrow;
    logic wrap16;
    logic gate_en;
  } agen_mode_t;
endpackage

// File: rtl/idx_shape.sv
module idx_shape #(
  parameter int OFS_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             narrow_i,
  input  logic [OFS_W-1:0] index_i,
  output logic [OFS_W-1:0] index_o
);
  localparam int PAD_W = OFS_W - NARROW_W;

  always_comb begin
    if (narrow_i) index_o = {{PAD_W{1'b0}}, index_i[NARROW_W-1:0]};
    else          index_o = index_i;
  end

  // R4
  always_comb begin
    narrow_hi_chk: assert (!narrow_i || index_o[OFS_W-1:NARROW_W] == '0);
  end
endmodule

// File: rtl/bank_sum.sv
module bank_sum #(
  parameter int BANK_W = 8,
  parameter int OFS_W  = 16,
  localparam int ADDR_W = BANK_W + OFS_W
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFS_W-1:0]  operand_i,
  input  logic [OFS_W-1:0]  index_i,
  output logic [ADDR_W-1:0] full_o,
  output logic [ADDR_W-1:0] wrapped_o,
  output logic              carry_o,
  output logic              cross_o
);
  function automatic logic [ADDR_W-1:0] full_add(
    input logic [BANK_W-1:0] b, input logic [OFS_W-1:0] o, input logic [OFS_W-1:0] x);
    return {b, {OFS_W{1'b0}}} + {{BANK_W{1'b0}}, o} + {{BANK_W{1'b0}}, x};
  endfunction

  function automatic logic [OFS_W:0] low_add(
    input logic [OFS_W-1:0] o, input logic [OFS_W-1:0] x);
    return {1'b0, o} + {1'b0, x};
  endfunction

  logic [OFS_W:0] low_sum;

  always_comb begin
    low_sum   = low_add(operand_i, index_i);
    full_o    = full_add(bank_i, operand_i, index_i);
    wrapped_o = {bank_i, low_sum[OFS_W-1:0]};
    carry_o   = low_sum[OFS_W];
    cross_o   = full_o[ADDR_W-1:OFS_W] != bank_i;
  end

  // R2
  always_comb begin
    carry_cross_chk: assert (carry_o == cross_o);
  end
endmodule

// File: rtl/hi_gate.sv
module hi_gate #(
  parameter int BANK_W = 8,
  parameter int OFS_W  = 16,
  localparam int ADDR_W = BANK_W + OFS_W
) (
  input  logic              emu_i,
  input  logic              gate_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              masked_o
);
  always_comb begin
    masked_o = emu_i & gate_en_i;
    addr_o   = masked_o ? {{BANK_W{1'b0}}, addr_i[OFS_W-1:0]} : addr_i;
  end
endmodule

// File: rtl/idx_bank_agen.sv
module idx_bank_agen #(
  parameter int BANK_W   = 8,
  parameter int OFS_W    = 16,
  parameter int NARROW_W = 8,
  localparam int ADDR_W  = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFS_W-1:0]  operand_i,
  input  logic [OFS_W-1:0]  index_i,
  input  logic              idx_narrow_i,
  input  logic              emu_i,
  input  logic              wrap16_i,
  input  logic              hi_gate_en_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cross_o
);
  import idx_agen_pkg::*;

  agen_mode_t        mode;
  logic              emu_q;
  logic [OFS_W-1:0]  idx_eff;
  logic [ADDR_W-1:0] sum_full, sum_wrap, sum_pick, sum_gated;
  logic              sum_carry, sum_cross, gate_hit;

  assign mode = '{narrow: idx_narrow_i, wrap16: wrap16_i, gate_en: hi_gate_en_i};

  always_ff @(posedge clk) begin
    if (rst) emu_q <= 1'b1;
    else     emu_q <= emu_i;
  end

  idx_shape #(.OFS_W(OFS_W), .NARROW_W(NARROW_W)) u_shape (
    .narrow_i(mode.narrow), .index_i(index_i), .index_o(idx_eff));

  bank_sum #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_sum (
    .bank_i(bank_i), .operand_i(operand_i), .index_i(idx_eff),
    .full_o(sum_full), .wrapped_o(sum_wrap), .carry_o(sum_carry), .cross_o(sum_cross));

  assign sum_pick = mode.wrap16 ? sum_wrap : sum_full;

  hi_gate #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_gate (
    .emu_i(emu_q), .gate_en_i(mode.gate_en), .addr_i(sum_pick),
    .addr_o(sum_gated), .masked_o(gate_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      cross_o <= 1'b0;
    end else if (strobe_i) begin
      addr_o  <= sum_gated;
      cross_o <= sum_cross;
    end
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe_i |=> ($stable(addr_o) && $stable(cross_o)));

  // R6
  gate_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && gate_hit) |=> addr_o[ADDR_W-1:OFS_W] == '0);

  // R5
  wrap_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && wrap16_i && !gate_hit) |=> addr_o[ADDR_W-1:OFS_W] == $past(bank_i));

  // R8
  cross_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && !wrap16_i && !gate_hit) |=>
      cross_o == (addr_o[ADDR_W-1:OFS_W] != $past(bank_i)));

  // R2
  carry_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && sum_carry) |=> cross_o);

  // R7
  emu_reset_chk: assert property (@(posedge clk) rst |=> emu_q);

  // R10
  reset_clear_chk: assert property (@(posedge clk) rst |=> (addr_o == '0 && !cross_o));
endmodule

// File: tb/sim_idx_bank_agen.sv
`timescale 1ns/1ps
module sim_idx_bank_agen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe_i = 1'b0;
  logic [7:0]  bank_i = '0;
  logic [15:0] operand_i = '0;
  logic [15:0] index_i = '0;
  logic        idx_narrow_i = 1'b0;
  logic        emu_i = 1'b1;
  logic        wrap16_i = 1'b0;
  logic        hi_gate_en_i = 1'b0;
  logic [23:0] addr_o;
  logic        cross_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  int emu_state = 1;

  always #4 clk = ~clk;

  idx_bank_agen u0 (.*);

  task automatic check(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic int model_addr(int b, int o, int x, int nar, int wr, int emu, int ge);
    int xi, s;
    xi = nar ? (x % 256) : x;
    if (wr) s = b * 65536 + ((o + xi) % 65536);
    else    s = (b * 65536 + o + xi) % 16777216;
    if (emu != 0 && ge != 0) s = s % 65536;
    return s;
  endfunction

  function automatic int model_cross(int b, int o, int x, int nar);
    int xi;
    xi = nar ? (x % 256) : x;
    return ((((b * 65536 + o + xi) / 65536) % 256) != b) ? 1 : 0;
  endfunction

  task automatic set_emu(input bit e);
    @(negedge clk);
    emu_i = e;
    @(negedge clk);
    emu_state = e;
  endtask

  task automatic apply(input string tag, input int b, input int o, input int x,
                       input bit nar, input bit wr, input bit ge);
    @(negedge clk);
    bank_i = b[7:0]; operand_i = o[15:0]; index_i = x[15:0];
    idx_narrow_i = nar; wrap16_i = wr; hi_gate_en_i = ge; strobe_i = 1'b1;
    @(negedge clk);
    strobe_i = 1'b0;
    check(tag, int'(addr_o), model_addr(b, o, x, nar, wr, emu_state, ge));
    check("R8 cross", int'(cross_o), model_cross(b, o, x, nar));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 addr", int'(addr_o), 0);
    check("R10 cross", int'(cross_o), 0);
    // R7: emu_i low at release, first strobe still sees state 1
    emu_i = 1'b0; rst = 1'b0;
    bank_i = 8'h5A; operand_i = 16'h1234; index_i = 16'h0001;
    idx_narrow_i = 0; wrap16_i = 0; hi_gate_en_i = 1; strobe_i = 1'b1;
    @(negedge clk);
    strobe_i = 1'b0;
    check("R7 first strobe gated", int'(addr_o), 24'h001235);
    emu_state = 0;
    apply("R7 state follows input", 8'h5A, 16'h1234, 1, 0, 0, 1);

    // R1 plain sums
    for (int k = 0; k < 64; k++) apply("R1 sum", 8'h12, 16'h3400 + k * 97, k * 513, 0, 0, 0);

    // R2 carry into bank, both emulation states
    for (int e = 0; e < 2; e++) begin
      set_emu(e[0]);
      for (int k = 0; k < 256; k++) apply("R2 carry", 8'h00 + e * 8'h40, 16'hFF80, k, 0, 0, 0);
    end
    apply("R2 example", 0, 16'hFFFF, 1, 0, 0, 0);
    check("R2 example value", int'(addr_o), 24'h010000);

    // R3 modulo 2^24
    apply("R3 top wrap", 8'hFF, 16'hFFFF, 1, 0, 0, 0);
    check("R3 example value", int'(addr_o), 0);
    apply("R3 top wrap max", 8'hFF, 16'hFFFF, 16'hFFFF, 0, 0, 0);
    for (int k = 0; k < 64; k++) apply("R3 sweep", 8'hFF, 16'hFFC0, k * 3, 0, 0, 0);

    // R4 narrow index
    for (int k = 0; k < 256; k++) apply("R4 narrow", 8'h21, 16'hFFA0, 16'hAB00 + k, 1, 0, 0);
    apply("R4 wide", 8'h21, 16'h1000, 16'hAB01, 0, 0, 0);

    // R5 compatibility wrap
    apply("R5 example", 0, 16'hFFF0, 16'h0010, 0, 1, 0);
    check("R5 example value", int'(addr_o), 0);
    for (int k = 0; k < 64; k++) apply("R5 wrap", 8'h34, 16'hFFE0, k, 0, 1, 0);

    // R6 gate in both emulation states, with and without wrap
    for (int e = 0; e < 2; e++) begin
      set_emu(e[0]);
      for (int k = 0; k < 32; k++) apply("R6 gate", 8'h7C, 16'hFFF0, k, 0, k[0], 1);
    end
    set_emu(1);
    apply("R6 gate off", 8'h7C, 16'h0100, 5, 0, 0, 0);

    // R9 hold with no strobe
    apply("R9 load", 8'h44, 16'hFFFF, 2, 0, 0, 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      bank_i = k[7:0]; operand_i = 16'h0F0F; index_i = k[15:0];
      wrap16_i = k[0]; hi_gate_en_i = k[1];
      @(negedge clk);
      check("R9 hold addr", int'(addr_o), 24'h450001);
      check("R9 hold cross", int'(cross_o), 1);
    end

    // R10 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 clear addr", int'(addr_o), 0);
    check("R10 clear cross", int'(cross_o), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule